// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Busy Tracking

This block turns bytes into asynchronous serial frames. Bytes enter a 16-entry queue through a one-cycle write strobe. Whenever the transmitter is enabled and the queue holds data, the frame engine takes the oldest byte and sends it. It sends a start bit, then 5 to 8 data bits, then an optional parity bit, then one or two stop bits. Each bit lasts sixteen pulses of an external 16x baud enable. Frames follow one another with no gap until the queue runs dry.

The busy output reports whether work is left. This means a byte is waiting or a frame is still on the line. It does not depend on the enable. Software can therefore drop the enable and still poll busy to learn when the last stop bit has gone out. The line format is sampled when a frame begins, so a format change never corrupts a frame that is already being sent.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset the serial line is high, the queue-empty flag is high, the queue-full flag is low and busy is low.
- R2: A frame is a low start bit, then the data bits LSB first, then stop bits that are high. Every bit lasts 16 pulses of `tick16`. The data length is `len_sel` + 5, so code 0 gives 5 bits and code 3 gives 8 bits.
- R3: When `parity_on` is 1, a parity bit follows the data bits. With `parity_odd` = 0 the parity bit makes the count of ones over the data bits and the parity bit even. With `parity_odd` = 1 it makes that count odd.
- R4: `stop_two` = 0 sends one stop bit and `stop_two` = 1 sends two stop bits.
- R5: While enabled, frames are sent back to back in write order until the queue is empty. The next byte is taken in the same cycle that the previous frame's last stop bit ends.
- R6: The queue holds 16 bytes. The full flag is high at 16 entries and the empty flag is high at 0. A write while the full flag is high is dropped, even when a byte leaves in the same cycle. A write and a removal in the same cycle leave the count unchanged.
- R7: Busy goes high in the cycle after a byte is written into an empty, idle transmitter, whether or not it is enabled.
- R8: Busy falls only once the queue is empty and the last stop bit has finished. Busy low always means the line is high.
- R9: With the enable low, no new frame starts. A frame already in progress is completed, and busy stays high while bytes remain queued.
- R10: Length, parity and stop settings are captured when a frame begins. Changes during the frame apply from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe for one byte into the queue |
| wr_byte | input | 8 | Byte to queue |
| tx_en | input | 1 | Allows new frames to start |
| len_sel | input | 2 | Data length code (length = code + 5) |
| parity_on | input | 1 | Adds a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_two | input | 1 | 1 selects two stop bits |
| tick16 | input | 1 | Baud enable at 16 times the bit rate |
| tx_line | output | 1 | Serial output, idles high |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_full | output | 1 | Queue holds 16 bytes |
| tx_busy | output | 1 | Queued data or a frame in flight |

## Verification
Two events can land in the same cycle: a byte is written into the queue, and the frame engine removes a byte from it. The first case is a write issued in exactly the cycle when the engine takes the only queued byte. The second is a write that coincides with a removal from a full queue, which must be dropped. The bench sets up both and also chains a removal onto the end of a stop bit. A behavioural model built from a byte queue and a list of frame bits predicts the line, both flags and busy. These are compared on every clock, so a wrong count or a lost or duplicated byte appears as a mismatch.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PARITY,
        FR_STOP
    } fr_state_e;

    // length code 0..3 maps to 5..8 data bits
    function automatic logic [3:0] len_code_to_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/sftx_queue.sv
module sftx_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } q_regs_t;

    q_regs_t      q_d, q_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         accept, take;

    assign empty  = (q_q.count == '0);
    assign full   = (q_q.count == CW'(DEPTH));
    assign head   = mem_q[q_q.rd_ptr];
    assign accept = push && !full;
    assign take   = pop && !empty;

    always_comb begin
        q_d = q_q;
        if (accept) begin
            q_d.wr_ptr = (q_q.wr_ptr == AW'(DEPTH - 1)) ? '0 : q_q.wr_ptr + 1'b1;
        end
        if (take) begin
            q_d.rd_ptr = (q_q.rd_ptr == AW'(DEPTH - 1)) ? '0 : q_q.rd_ptr + 1'b1;
        end
        case ({accept, take})
            2'b10:   q_d.count = q_q.count + 1'b1;
            2'b01:   q_d.count = q_q.count - 1'b1;
            default: q_d.count = q_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[q_q.wr_ptr] <= push_data;
    end

    // R6
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/sftx_framer.sv
module sftx_framer
    import sftx_pkg::*;
#(
    parameter int W   = 8,
    parameter int OSR = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         q_empty,
    input  logic [W-1:0] q_head,
    input  logic [1:0]   len_code,
    input  logic         par_en,
    input  logic         par_odd,
    input  logic         two_stop,
    input  logic         tick,
    output logic         pop,
    output logic         txd,
    output logic         active
);
    localparam int TW = $clog2(OSR);
    localparam int BW = $clog2(W) + 1;

    typedef struct packed {
        fr_state_e      st;
        logic [TW-1:0]  tcnt;
        logic [BW-1:0]  bcnt;
        logic [BW-1:0]  nbits;
        logic [W-1:0]   sh;
        logic           par_bit;
        logic           use_par;
        logic           two;
        logic           stop_idx;
    } fr_regs_t;

    fr_regs_t       r_d, r_q;
    logic           bit_end;
    logic           frame_done;
    logic [BW-1:0]  new_bits;
    logic [W-1:0]   mask;

    assign new_bits = BW'(len_code_to_bits(len_code));

    always_comb begin
        for (int i = 0; i < W; i++) begin
            mask[i] = (BW'(i) < new_bits);
        end
    end

    always_comb begin
        r_d        = r_q;
        pop        = 1'b0;
        frame_done = 1'b0;
        bit_end    = tick && (r_q.tcnt == TW'(OSR - 1));
        if (r_q.st != FR_IDLE && tick) begin
            r_d.tcnt = bit_end ? '0 : r_q.tcnt + 1'b1;
        end
        case (r_q.st)
            FR_START: if (bit_end) begin
                r_d.st   = FR_DATA;
                r_d.bcnt = '0;
            end
            FR_DATA: if (bit_end) begin
                r_d.sh = r_q.sh >> 1;
                if (r_q.bcnt == r_q.nbits - 1'b1) begin
                    r_d.st       = r_q.use_par ? FR_PARITY : FR_STOP;
                    r_d.stop_idx = 1'b0;
                end else begin
                    r_d.bcnt = r_q.bcnt + 1'b1;
                end
            end
            FR_PARITY: if (bit_end) begin
                r_d.st       = FR_STOP;
                r_d.stop_idx = 1'b0;
            end
            FR_STOP: if (bit_end) begin
                if (r_q.two && !r_q.stop_idx) begin
                    r_d.stop_idx = 1'b1;
                end else begin
                    r_d.st     = FR_IDLE;
                    frame_done = 1'b1;
                end
            end
            default: ;
        endcase
        if ((r_q.st == FR_IDLE || frame_done) && enable && !q_empty) begin
            pop          = 1'b1;
            r_d.st       = FR_START;
            r_d.tcnt     = '0;
            r_d.bcnt     = '0;
            r_d.sh       = q_head;
            r_d.nbits    = new_bits;
            r_d.par_bit  = (^(q_head & mask)) ^ par_odd;
            r_d.use_par  = par_en;
            r_d.two      = two_stop;
            r_d.stop_idx = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: FR_IDLE, default: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        case (r_q.st)
            FR_START:  txd = 1'b0;
            FR_DATA:   txd = r_q.sh[0];
            FR_PARITY: txd = r_q.par_bit;
            default:   txd = 1'b1;
        endcase
    end

    assign active = (r_q.st != FR_IDLE);

    // R9
    no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !active) |=> !active);

    // R2
    line_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(txd));

endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit #(
    parameter int DATA_W      = 8,
    parameter int QUEUE_DEPTH = 16,
    parameter int OVERSAMPLE  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              tx_en,
    input  logic [1:0]        len_sel,
    input  logic              parity_on,
    input  logic              parity_odd,
    input  logic              stop_two,
    input  logic              tick16,
    output logic              tx_line,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              tx_busy
);
    logic              pop;
    logic              active;
    logic [DATA_W-1:0] head;

    sftx_queue #(.W(DATA_W), .DEPTH(QUEUE_DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data (wr_byte),
        .pop       (pop),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    sftx_framer #(.W(DATA_W), .OSR(OVERSAMPLE)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (tx_en),
        .q_empty  (fifo_empty),
        .q_head   (head),
        .len_code (len_sel),
        .par_en   (parity_on),
        .par_odd  (parity_odd),
        .two_stop (stop_two),
        .tick     (tick16),
        .pop      (pop),
        .txd      (tx_line),
        .active   (active)
    );

    assign tx_busy = !fifo_empty || active;

    // R8
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    // R7
    busy_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !wr_valid) |=> !tx_busy);

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

endmodule

// File: tb/tb_serial_tx_unit.sv
module tb_serial_tx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       tx_en = 1'b0;
    logic [1:0] len_sel = 2'd3;
    logic       parity_on = 1'b0;
    logic       parity_odd = 1'b0;
    logic       stop_two = 1'b0;
    logic       tick16 = 1'b0;
    logic       tx_line, fifo_empty, fifo_full, tx_busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_div = 1;
    int tick_ctr = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    serial_tx_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .tx_en(tx_en), .len_sel(len_sel), .parity_on(parity_on),
        .parity_odd(parity_odd), .stop_two(stop_two), .tick16(tick16),
        .tx_line(tx_line), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .tx_busy(tx_busy)
    );

    // baud enable generator
    always @(negedge clk) begin
        tick_ctr = tick_ctr + 1;
        tick16 = (tick_ctr % tick_div) == 0;
    end

    // behavioural reference model
    byte unsigned mq[$];
    bit           mbits[$];
    bit           mact = 1'b0;
    int           mtick = 0;
    bit           m_fullb, m_emptyb;

    task automatic build_frame(input byte unsigned d);
        int  n;
        bit  p;
        n = int'(len_sel) + 5;
        p = parity_odd;
        mbits.delete();
        mbits.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            mbits.push_back(d[i]);
            p = p ^ d[i];
        end
        if (parity_on) mbits.push_back(p);
        mbits.push_back(1'b1);
        if (stop_two) mbits.push_back(1'b1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            mbits.delete();
            mact = 1'b0;
            mtick = 0;
        end else begin
            m_fullb  = (mq.size() == 16);
            m_emptyb = (mq.size() == 0);
            if (mact && tick16) begin
                if (mtick == 15) begin
                    mtick = 0;
                    void'(mbits.pop_front());
                    if (mbits.size() == 0) mact = 1'b0;
                end else begin
                    mtick = mtick + 1;
                end
            end
            if (!mact && tx_en && !m_emptyb) begin
                build_frame(mq.pop_front());
                mact = 1'b1;
                mtick = 0;
            end
            if (wr_valid && !m_fullb) mq.push_back(wr_byte);
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    // compare with the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            automatic bit e_txd  = mact ? mbits[0] : 1'b1;
            automatic bit e_busy = mact || (mq.size() != 0);
            check(tx_line == e_txd, "R2 R3 R4 R5 R10 line", tx_line, e_txd);
            check(fifo_empty == (mq.size() == 0), "R6 empty flag", fifo_empty, mq.size() == 0);
            check(fifo_full == (mq.size() == 16), "R6 full flag", fifo_full, mq.size() == 16);
            check(tx_busy == e_busy, "R8 R9 busy", tx_busy, e_busy);
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_byte  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (tx_busy) @(negedge clk);
    endtask

    task automatic set_fmt(input logic [1:0] l, input bit pe, input bit po, input bit ts);
        len_sel = l; parity_on = pe; parity_odd = po; stop_two = ts;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(tx_line == 1'b1, "R1 line after reset", tx_line, 1);
        check(fifo_empty == 1'b1, "R1 empty after reset", fifo_empty, 1);
        check(fifo_full == 1'b0, "R1 full after reset", fifo_full, 0);
        check(tx_busy == 1'b0, "R1 busy after reset", tx_busy, 0);
        cmp_on = 1'b1;

        // R7: busy rises on first write while disabled
        @(negedge clk);
        wr_valid = 1'b1; wr_byte = 8'hA5;
        @(negedge clk);
        wr_valid = 1'b0;
        check(tx_busy == 1'b1, "R7 busy after first write", tx_busy, 1);

        // R6: fill to 16, then one dropped write
        for (int i = 1; i < 16; i++) push_byte(8'(i * 17 + 3));
        check(fifo_full == 1'b1, "R6 full at 16", fifo_full, 1);
        push_byte(8'hEE);
        check(fifo_full == 1'b1, "R6 full after dropped write", fifo_full, 1);

        // R9: nothing starts while disabled
        repeat (50) @(negedge clk);
        check(tx_line == 1'b1, "R9 line idle while disabled", tx_line, 1);
        check(tx_busy == 1'b1, "R9 busy while disabled", tx_busy, 1);

        // R6: removal and dropped write in the same cycle from a full queue
        tx_en = 1'b1; wr_valid = 1'b1; wr_byte = 8'h77;
        @(negedge clk);
        wr_valid = 1'b0;
        check(fifo_full == 1'b0, "R6 write dropped during removal", fifo_full, 0);

        // R5: drain back to back, 8N1, fast ticks
        wait_idle();
        check(fifo_empty == 1'b1 && tx_line == 1'b1, "R8 drained", tx_line, 1);

        // R2 R3 R4: several formats, slower ticks
        tick_div = 2;
        for (int f = 0; f < 4; f++) begin
            set_fmt(2'(f), f[0], f[1], f != 1);
            push_byte(8'h3C ^ 8'(f * 37));
            push_byte(8'hC1 + 8'(f));
            push_byte(8'h96);
            wait_idle();
        end
        set_fmt(2'd2, 1'b1, 1'b1, 1'b1);
        push_byte(8'hFF);
        push_byte(8'h00);
        wait_idle();

        // R10: change format mid-frame
        tick_div = 1;
        set_fmt(2'd3, 1'b0, 1'b0, 1'b0);
        push_byte(8'h5A);
        push_byte(8'hA3);
        repeat (40) @(negedge clk);
        set_fmt(2'd0, 1'b1, 1'b0, 1'b1);
        wait_idle();

        // R9: disable mid-frame, frame completes, busy holds
        set_fmt(2'd3, 1'b1, 1'b0, 1'b0);
        push_byte(8'h11);
        push_byte(8'h22);
        push_byte(8'h33);
        repeat (40) @(negedge clk);
        tx_en = 1'b0;
        repeat (300) @(negedge clk);
        check(tx_line == 1'b1, "R9 line idle after disable", tx_line, 1);
        check(tx_busy == 1'b1, "R9 busy held after disable", tx_busy, 1);
        tx_en = 1'b1;
        wait_idle();

        // R6 R7: write in the very cycle the only byte is taken
        @(negedge clk);
        wr_valid = 1'b1; wr_byte = 8'h81;
        @(negedge clk);
        wr_byte = 8'h42;
        @(negedge clk);
        wr_valid = 1'b0;
        check(fifo_empty == 1'b0, "R6 write during removal kept", fifo_empty, 0);
        wait_idle();
        check(tx_busy == 1'b0, "R8 busy clear at end", tx_busy, 0);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule